// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A requester presents a virtual address together with the frame number of the root table. The walker reads one entry from the root table and, if that entry is valid, one entry from the leaf table that it points to. It then returns either the physical address or a fault that names the level where the walk stopped. Both reads go out through a single-word read port that has a request/ready handshake and a separate response strobe.

The virtual address has three fields. Bits 31:22 index the root table, bits 21:12 index the leaf table, and bits 11:0 are the byte offset within a 4 KB page. Each table entry is one 32-bit word, so a table of 1024 entries fills exactly one page. An entry is laid out as follows: bit 0 is the valid flag, bits 31:12 are a 20-bit frame number, and bits 11:1 hold the referenced, modified and protection flags, which the walker carries but never interprets. Only one walk runs at a time, and `busy` holds off new requests until the result has been returned.

The controller has six states. IDLE waits for `req_valid`. ROOT_REQ issues the root-entry read and leaves on `mem_rd_ready`. ROOT_WAIT waits for `mem_rsp_valid`; it moves to LEAF_REQ when the entry is valid and to DONE (a level-0 fault) when it is not. LEAF_REQ issues the leaf-entry read and leaves on `mem_rd_ready`. LEAF_WAIT waits for `mem_rsp_valid` and then moves to DONE, which reports either a translation or a level-1 fault. DONE holds for one cycle and returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `mem_rd_valid` and `done_valid` are 0.
- R2: The first read of a walk targets byte address `{ptbr_frame, 12'h000} + 4*vaddr[31:22]`.
- R3: After a valid root entry (bit 0 = 1) is returned, the second read targets `{root_entry[31:12], 12'h000} + 4*vaddr[21:12]`. This read is issued only after the root response has arrived.
- R4: When the leaf entry is valid, `done_fault`=0 and `done_paddr` = `{leaf_entry[31:12], vaddr[11:0]}`.
- R5: A root entry with bit 0 = 0 ends the walk after exactly one read, with `done_fault`=1, `done_level`=0 and `done_paddr`=0.
- R6: A leaf entry with bit 0 = 0 ends the walk after two reads, with `done_fault`=1, `done_level`=1 and `done_paddr`=0.
- R7: Entry bits 11:1 have no effect on the walk. On a successful walk `done_attr` returns bits 11:0 of the leaf entry; on a fault `done_attr` is 0.
- R8: A request is accepted only when `busy` is 0. `busy` rises in the next cycle and stays high through the cycle of `done_valid`. A request presented while `busy` is 1 is ignored. No read is issued while `busy` is 0.
- R9: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, `mem_rd_addr` stays unchanged. Each accepted read drops `mem_rd_valid` in the next cycle.
- R10: `done_valid` is a one-cycle pulse that carries `done_vaddr` = the accepted virtual address. The root frame is sampled at acceptance, so changes to `ptbr_frame` during a walk have no effect.
- R11: A `mem_rsp_valid` pulse that arrives while no read is outstanding is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| ptbr_frame | input | 20 | Frame number of the root table |
| busy | output | 1 | Walk in progress; requests are ignored |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Entry word returned |
| done_valid | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Walk hit an invalid entry |
| done_level | output | 1 | Deepest level read: 0 root, 1 leaf |
| done_vaddr | output | 32 | Virtual address of this result |
| done_paddr | output | 32 | Physical address (0 on fault) |
| done_attr | output | 12 | Leaf entry low bits (0 on fault) |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a walk at the same moment as a change to the root frame. The stimulus reaches it by making the memory model slow, with several cycles of ready stall and a long response delay. It then raises a second request with a different address and switches `ptbr_frame` to an unmapped table while the first walk is still waiting. The model shows that only the first address is translated, that it uses the old root, and that no further read follows. Spurious responses are injected while the walker is idle, and ready stalls of different lengths check that the address is held.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // log2 of the entry size in bytes: entries are one 32-bit word
    localparam int unsigned ENTRY_SHIFT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROOT_REQ,
        ST_ROOT_WAIT,
        ST_LEAF_REQ,
        ST_LEAF_WAIT,
        ST_DONE
    } walk_state_e;

    typedef enum logic {
        LVL_ROOT = 1'b0,
        LVL_LEAF = 1'b1
    } walk_level_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int unsigned IDX_W   = 10,
    parameter int unsigned OFF_W   = 12,
    parameter int unsigned VA_W    = 2 * IDX_W + OFF_W,
    parameter int unsigned FRAME_W = VA_W - OFF_W
) (
    input  logic               sel_leaf,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic [FRAME_W-1:0] leaf_frame,
    input  logic [VA_W-1:0]    vaddr,
    output logic [VA_W-1:0]    entry_addr
);
    import ptw_pkg::*;

    localparam int unsigned LEVELS = 2;

    // index field per level, level 0 is the most significant
    logic [IDX_W-1:0] idx [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx[g] = vaddr[OFF_W + (LEVELS - 1 - g) * IDX_W +: IDX_W];
    end

    logic [FRAME_W-1:0] tbl_frame;
    logic [IDX_W-1:0]   cur_idx;
    logic [VA_W-1:0]    tbl_base;
    logic [VA_W-1:0]    idx_bytes;

    always_comb begin
        tbl_frame  = sel_leaf ? leaf_frame : root_frame;
        cur_idx    = sel_leaf ? idx[1] : idx[0];
        tbl_base   = {tbl_frame, {OFF_W{1'b0}}};
        idx_bytes  = VA_W'({cur_idx, {ENTRY_SHIFT{1'b0}}});
        entry_addr = tbl_base + idx_bytes;
    end

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int unsigned PTE_W     = 32,
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned VALID_POS = 0
) (
    input  logic [PTE_W-1:0]       pte,
    output logic                   present,
    output logic [PTE_W-OFF_W-1:0] frame,
    output logic [OFF_W-1:0]       attr
);

    always_comb begin
        present = pte[VALID_POS];
        frame   = pte[PTE_W-1:OFF_W];
        attr    = pte[OFF_W-1:0];
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int unsigned IDX_W     = 10,
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned VALID_POS = 0,
    localparam int unsigned VA_W     = 2 * IDX_W + OFF_W,
    localparam int unsigned FRAME_W  = VA_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] ptbr_frame,
    output logic               busy,
    output logic               mem_rd_valid,
    output logic [VA_W-1:0]    mem_rd_addr,
    input  logic               mem_rd_ready,
    input  logic               mem_rsp_valid,
    input  logic [VA_W-1:0]    mem_rsp_data,
    output logic               done_valid,
    output logic               done_fault,
    output logic               done_level,
    output logic [VA_W-1:0]    done_vaddr,
    output logic [VA_W-1:0]    done_paddr,
    output logic [OFF_W-1:0]   done_attr
);
    import ptw_pkg::*;

    walk_state_e state_q, state_d;

    logic [VA_W-1:0]    va_q;
    logic [FRAME_W-1:0] root_q;
    logic [FRAME_W-1:0] leaf_tbl_q;
    logic               fault_q;
    walk_level_e        level_q;
    logic [VA_W-1:0]    paddr_q;
    logic [OFF_W-1:0]   attr_q;

    logic               pte_present;
    logic [FRAME_W-1:0] pte_frame;
    logic [OFF_W-1:0]   pte_attr;
    logic               sel_leaf;
    logic [VA_W-1:0]    entry_addr;

    logic accept;
    logic root_rsp;
    logic leaf_rsp;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign root_rsp = (state_q == ST_ROOT_WAIT) && mem_rsp_valid;
    assign leaf_rsp = (state_q == ST_LEAF_WAIT) && mem_rsp_valid;

    ptw_pte_decode #(
        .PTE_W    (VA_W),
        .OFF_W    (OFF_W),
        .VALID_POS(VALID_POS)
    ) i_decode (
        .pte    (mem_rsp_data),
        .present(pte_present),
        .frame  (pte_frame),
        .attr   (pte_attr)
    );

    ptw_addr_gen #(
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .VA_W   (VA_W),
        .FRAME_W(FRAME_W)
    ) i_addr (
        .sel_leaf  (sel_leaf),
        .root_frame(root_q),
        .leaf_frame(leaf_tbl_q),
        .vaddr     (va_q),
        .entry_addr(entry_addr)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid)     state_d = ST_ROOT_REQ;
            ST_ROOT_REQ:  if (mem_rd_ready)  state_d = ST_ROOT_WAIT;
            ST_ROOT_WAIT: if (mem_rsp_valid) state_d = pte_present ? ST_LEAF_REQ : ST_DONE;
            ST_LEAF_REQ:  if (mem_rd_ready)  state_d = ST_LEAF_WAIT;
            ST_LEAF_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:                         state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk context and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q       <= '0;
            root_q     <= '0;
            leaf_tbl_q <= '0;
            fault_q    <= 1'b0;
            level_q    <= LVL_ROOT;
            paddr_q    <= '0;
            attr_q     <= '0;
        end else begin
            if (accept) begin
                va_q    <= req_vaddr;
                root_q  <= ptbr_frame;
                fault_q <= 1'b0;
                level_q <= LVL_ROOT;
                paddr_q <= '0;
                attr_q  <= '0;
            end
            if (root_rsp) begin
                if (pte_present) leaf_tbl_q <= pte_frame;
                else             fault_q    <= 1'b1;
            end
            if (leaf_rsp) begin
                level_q <= LVL_LEAF;
                if (pte_present) begin
                    paddr_q <= {pte_frame, va_q[OFF_W-1:0]};
                    attr_q  <= pte_attr;
                end else begin
                    fault_q <= 1'b1;
                end
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy         = (state_q != ST_IDLE);
        mem_rd_valid = (state_q == ST_ROOT_REQ) || (state_q == ST_LEAF_REQ);
        sel_leaf     = (state_q == ST_LEAF_REQ);
        mem_rd_addr  = entry_addr;
        done_valid   = (state_q == ST_DONE);
        done_fault   = fault_q;
        done_level   = level_q;
        done_vaddr   = va_q;
        done_paddr   = paddr_q;
        done_attr    = attr_q;
    end

    // R8: an idle request starts a read in the next cycle
    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (busy && mem_rd_valid));

    // R9: read held stable until accepted
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R3: valid root entry triggers the leaf read
    p_leaf_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROOT_WAIT && mem_rsp_valid && mem_rsp_data[VALID_POS]) |=> mem_rd_valid);

    // R4: offset passes through unchanged
    p_offset_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault) |-> (done_paddr[OFF_W-1:0] == done_vaddr[OFF_W-1:0]));

    // R5: a fault reports no address
    p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |-> (done_paddr == '0));

    // R10: result strobe lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [19:0] ptbr_frame;
    logic        busy;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done_valid;
    logic        done_fault;
    logic        done_level;
    logic [31:0] done_vaddr;
    logic [31:0] done_paddr;
    logic [11:0] done_attr;

    always #4 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .ptbr_frame(ptbr_frame), .busy(busy), .mem_rd_valid(mem_rd_valid),
        .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_fault(done_fault), .done_level(done_level),
        .done_vaddr(done_vaddr), .done_paddr(done_paddr), .done_attr(done_attr)
    );

    typedef struct {
        logic [31:0] va;
        logic [31:0] a1;
        logic [31:0] a2;
        logic [31:0] paddr;
        logic [11:0] attr;
        bit          fault;
        bit          lvl;
        int          n;
    } exp_t;

    int total = 0;
    int bad   = 0;
    logic [31:0] mem [int unsigned];
    exp_t cur;
    bit   have_cur = 0;
    int   rd_seen  = 0;
    int   done_cnt = 0;
    bit   exp_busy = 0;
    bit   prev_done = 0;
    int   stall_cyc = 0;
    int   rsp_dly   = 1;
    int   spur_cnt  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    // behavioural walk outcome
    function automatic exp_t model(input logic [31:0] va, input logic [19:0] base);
        exp_t e;
        logic [31:0] e1, e2;
        e.va = va; e.a2 = 0; e.paddr = 0; e.attr = 0; e.fault = 0; e.lvl = 0;
        e.a1 = {base, 12'h000} + {20'h0, va[31:22], 2'b00};
        e1 = rd(e.a1);
        e.n = 1;
        if (!e1[0]) begin
            e.fault = 1;
            return e;
        end
        e.a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
        e2 = rd(e.a2);
        e.n = 2;
        e.lvl = 1;
        if (!e2[0]) e.fault = 1;
        else begin
            e.paddr = {e2[31:12], va[11:0]};
            e.attr  = e2[11:0];
        end
        return e;
    endfunction

    // per-cycle reference comparison
    initial begin
        forever begin
            @(negedge clk); #1;
            if (!rst_n) begin
                exp_busy = 0; have_cur = 0; prev_done = 0;
            end else begin
                bit nb;
                chk(busy == exp_busy, "R8 busy", {31'h0, busy}, {31'h0, exp_busy});
                if (!exp_busy)
                    chk(!mem_rd_valid && !done_valid, "R11 idle quiet",
                        {30'h0, mem_rd_valid, done_valid}, 32'h0);
                nb = exp_busy;
                if (done_valid) begin
                    chk(!prev_done, "R10 pulse", 32'h1, 32'h0);
                    chk(have_cur, "R8 unexpected result", 32'h1, 32'h0);
                    chk(done_vaddr == cur.va, "R10 vaddr", done_vaddr, cur.va);
                    chk(done_fault == cur.fault, cur.lvl ? "R6 fault" : "R5 fault",
                        {31'h0, done_fault}, {31'h0, cur.fault});
                    chk(done_level == cur.lvl, "R6 level", {31'h0, done_level}, {31'h0, cur.lvl});
                    chk(done_paddr == cur.paddr, "R4 paddr", done_paddr, cur.paddr);
                    chk(done_attr == cur.attr, "R7 attr", {20'h0, done_attr}, {20'h0, cur.attr});
                    chk(rd_seen == cur.n, "R5 read count", rd_seen, cur.n);
                    have_cur = 0;
                    nb = 0;
                    done_cnt++;
                end
                prev_done = done_valid;
                if (req_valid && !busy) begin
                    cur = model(req_vaddr, ptbr_frame);
                    have_cur = 1;
                    rd_seen = 0;
                    nb = 1;
                end
                exp_busy = nb;
            end
        end
    end

    // memory responder
    initial begin
        mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_rd_valid) begin
                logic [31:0] a;
                mem_rsp_valid = 0;
                a = mem_rd_addr;
                if (!have_cur) chk(0, "R8 read while idle", a, 32'h0);
                else if (rd_seen == 0) chk(a == cur.a1, "R2 root addr", a, cur.a1);
                else if (rd_seen == 1) chk(cur.n == 2 && a == cur.a2, "R3 leaf addr", a, cur.a2);
                else chk(0, "R5 extra read", a, 32'h0);
                rd_seen++;
                for (int s = 0; s < stall_cyc; s++) begin
                    @(negedge clk);
                    chk(mem_rd_valid && mem_rd_addr == a, "R9 hold", mem_rd_addr, a);
                end
                mem_rd_ready = 1;
                @(negedge clk);
                mem_rd_ready = 0;
                chk(!mem_rd_valid, "R9 drop", {31'h0, mem_rd_valid}, 32'h0);
                for (int d = 1; d < rsp_dly; d++) @(negedge clk);
                mem_rsp_valid = 1;
                mem_rsp_data  = rd(a);
                @(negedge clk);
                mem_rsp_valid = 0;
            end else begin
                mem_rsp_valid = (spur_cnt > 0);
                mem_rsp_data  = 32'hFFFF_F001;
                if (spur_cnt > 0) spur_cnt--;
            end
        end
    end

    task automatic run(input logic [31:0] va);
        int old;
        while (busy) @(negedge clk);
        old = done_cnt;
        req_valid = 1; req_vaddr = va;
        @(negedge clk);
        req_valid = 0;
        while (done_cnt == old) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; req_valid = 0; req_vaddr = 0; ptbr_frame = 20'h00040;
        repeat (4) @(negedge clk);
        chk(!busy, "R1 busy", {31'h0, busy}, 32'h0);
        chk(!mem_rd_valid, "R1 rd_valid", {31'h0, mem_rd_valid}, 32'h0);
        chk(!done_valid, "R1 done", {31'h0, done_valid}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !mem_rd_valid && !done_valid, "R1 after reset",
            {29'h0, busy, mem_rd_valid, done_valid}, 32'h0);

        mem[32'h0004_0004] = {20'h00051, 12'h003};
        mem[32'h0005_100C] = {20'hABCDE, 12'h01B};
        mem[32'h0005_101C] = 32'h0000_0FFE;
        mem[32'h0004_0FFC] = {20'h00077, 12'h001};
        mem[32'h0007_7FFC] = {20'h12345, 12'hFFF};
        mem[32'h0004_0000] = {20'h00060, 12'h001};
        mem[32'h0006_0000] = {20'h00001, 12'h001};

        // R4 R7: plain hit with flag bits set
        stall_cyc = 0; rsp_dly = 1; run(32'h0040_3ABC);
        // R5: root entry invalid
        stall_cyc = 3; rsp_dly = 2; run(32'h0140_0123);
        // R6 R7: leaf entry invalid but with flag bits set
        stall_cyc = 1; rsp_dly = 4; run(32'h0040_7555);
        // R2 R3: highest indices
        stall_cyc = 0; rsp_dly = 1; run(32'hFFFF_FFFF);
        // back-to-back with index zero
        run(32'h0000_0010);
        chk(done_paddr == 32'h0000_1010, "R4 index zero", done_paddr, 32'h0000_1010);

        // R8 R10: request and root change during a walk are ignored
        begin
            int old;
            stall_cyc = 2; rsp_dly = 3;
            old = done_cnt;
            req_valid = 1; req_vaddr = 32'h0040_3000;
            @(negedge clk);
            req_valid = 0;
            repeat (2) @(negedge clk);
            req_valid = 1; req_vaddr = 32'hFFFF_F000; ptbr_frame = 20'h00099;
            repeat (2) @(negedge clk);
            req_valid = 0;
            while (done_cnt == old) @(negedge clk);
            chk(done_paddr == 32'hABCD_E000, "R10 root sampled", done_paddr, 32'hABCD_E000);
            repeat (6) @(negedge clk);
            chk(!busy && done_cnt == old + 1, "R8 ignored request", done_cnt, old + 1);
            ptbr_frame = 20'h00040;
        end

        // R11: spurious responses while idle
        begin
            int old;
            old = done_cnt;
            spur_cnt = 2;
            repeat (6) @(negedge clk);
            chk(!busy && done_cnt == old, "R11 spurious", done_cnt, old);
            stall_cyc = 0; rsp_dly = 1;
            run(32'h0040_3ABC);
            chk(done_paddr == 32'hABCD_EABC, "R11 next walk", done_paddr, 32'hABCD_EABC);
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule